// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is the master side of a one-bit serial configuration port for a target FPGA. After a start request it resets the target through the program pin. It waits for the target's init pin to go low and then high again. It then takes configuration bytes from a valid/ready byte stream and shifts each byte out on a data pin, most significant bit first, with a generated configuration clock. Before each byte it checks the target's init and done pins for a CRC error. After the byte marked last, it keeps toggling the configuration clock with data held high until the target raises done.

All waits are bounded by a timeout counted in system clocks. The configuration clock speed is set by a parameter that gives the number of system clocks in each half-period. The result is reported by a one-cycle completion pulse that carries a two-bit status. The block sits between a bitstream source, such as a DMA or flash reader that feeds the byte stream, and the target's configuration pins.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is held and afterwards until a start, the outputs rest in this state: program low, configuration clock high, data high, busy low, ready low, completion low.
- R2: A start seen while idle raises program and busy on the next cycle. When init is low at a clock edge while program is high, program drops on the next cycle.
- R3: The init-low wait and the init-high wait each last at most TMO_CYC cycles. If a wait expires, a completion pulse with status 1 follows, exactly TMO_CYC cycles after program rises in the init-low case.
- R4: Each accepted byte appears on the data pin most significant bit first, one bit per configuration-clock period, BYTE_W bits per byte.
- R5: For each bit the configuration clock is low for HALF_CYC cycles and then high for HALF_CYC cycles. Data changes only when the clock falls, never on a rising edge.
- R6: In the state between bytes, if init is low while done is low, the load ends with status 2. No further byte is accepted.
- R7: Ready is high only in the state between bytes, and only while no CRC condition is present. A byte is taken at a clock edge where valid and ready are both high, and shifting starts on the next cycle with the clock low.
- R8: After the last byte has been shifted, data stays high and the clock keeps toggling with the same half-period. When done is high at a clock edge in that phase, a completion pulse with status 0 follows.
- R9: If done stays low for TMO_CYC cycles in the done-wait phase, the load ends with status 3.
- R10: The completion pulse lasts exactly one cycle. It is accompanied by busy low, and afterwards the outputs return to the idle state of R1.
- R11: A start request while a load is in progress has no effect: program stays low and the bitstream continues unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to begin a configuration load |
| busy_o | output | 1 | A load is in progress |
| s_valid_i | input | 1 | Byte stream: a byte is offered |
| s_data_i | input | BYTE_W | Byte stream: configuration byte |
| s_last_i | input | 1 | Byte stream: offered byte is the final one |
| s_ready_o | output | 1 | Byte stream: loader takes the offered byte |
| cmpl_o | output | 1 | One-cycle completion pulse |
| cmpl_status_o | output | 2 | Status with completion: 0 ok, 1 init timeout, 2 CRC error, 3 done timeout |
| cfg_prog_o | output | 1 | Program (target reset) request, high = asserted |
| cfg_clk_o | output | 1 | Configuration clock to the target |
| cfg_data_o | output | 1 | Serial configuration data to the target |
| tgt_init_n_i | input | 1 | Target init pin, active low |
| tgt_done_i | input | 1 | Target done pin, high = configured |

## Verification
The hardest case to reach is the CRC abort. Init has to fall while done is low, and that only matters once the loader is back between bytes. A pin change during shifting must therefore be ignored, while the same level must end the load at the next byte boundary. The stimulus pulls init low right after the first byte is accepted. It keeps a second byte offered on the stream, so any wrong acceptance would show up as extra bits at the target. A cycle-accurate behavioural model compares every output on every clock. A bench-side target also captures data on each rising configuration clock and checks the captured bits against the bytes that were sent.

// File: rtl/cfgl_pkg.sv
// Shared types for the serial configuration loader.
// Assumes: consumers import the package; state encoding is free to change.
package cfgl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_RELEASE,
        ST_READY,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_DONE_WAIT,
        ST_FINISH
    } cfgl_state_e;

    typedef enum logic [1:0] {
        CS_OK       = 2'd0,
        CS_INIT_TMO = 2'd1,
        CS_CRC      = 2'd2,
        CS_DONE_TMO = 2'd3
    } cfgl_status_e;

    // Width of a counter that must hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cfgl_timeout.sv
// Timeout counter: counts cycles while run is high, restarts on clear.
// Assumes: LIMIT >= 1; expired is high in the LIMIT-th running cycle.
module cfgl_timeout #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic expired
);
    import cfgl_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Advance the elapsed-cycle count, holding at the final value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    assert_count_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $past(run));

endmodule

// File: rtl/cfgl_halfper.sv
// Half-period divider for the configuration clock.
// Assumes: HALF >= 1; tick is high in the last cycle of each half-period.
module cfgl_halfper #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    import cfgl_pkg::*;

    localparam int unsigned W = cnt_width(HALF);
    localparam logic [W-1:0] LAST = W'(HALF - 1);

    logic [W-1:0] cnt;

    // Count cycles within the current half-period, wrapping on tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/cfgl_shifter.sv
// Byte serialiser: loads a byte and presents its bits MSB first.
// Assumes: shift is never requested on the final bit.
module cfgl_shifter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         bit_o,
    output logic         last_o
);
    import cfgl_pkg::*;

    localparam int unsigned IW = cnt_width(W);
    localparam logic [IW-1:0] LAST = IW'(W - 1);

    logic [W-1:0]  sh;
    logic [IW-1:0] idx;

    // Hold the byte and move the next bit to the top on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '1;
            idx <= '0;
        end else if (load) begin
            sh  <= din;
            idx <= '0;
        end else if (shift) begin
            sh  <= {sh[W-2:0], 1'b0};
            idx <= idx + 1'b1;
        end
    end

    assign bit_o  = sh[W-1];
    assign last_o = (idx == LAST);

    assert_no_shift_past_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last_o);

endmodule

// File: rtl/serial_cfg_loader.sv
// Serial configuration loader: target reset handshake, MSB-first bit
// serialisation with a divided clock, CRC check between bytes and a
// done-wait phase, all waits bounded by TMO_CYC system clocks.
// Assumes: target pins are already synchronised to clk.
module serial_cfg_loader #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned HALF_CYC = 4,
    parameter int unsigned TMO_CYC  = 2500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    input  logic              s_valid_i,
    input  logic [BYTE_W-1:0] s_data_i,
    input  logic              s_last_i,
    output logic              s_ready_o,
    output logic              cmpl_o,
    output logic [1:0]        cmpl_status_o,
    output logic              cfg_prog_o,
    output logic              cfg_clk_o,
    output logic              cfg_data_o,
    input  logic              tgt_init_n_i,
    input  logic              tgt_done_i
);
    import cfgl_pkg::*;

    cfgl_state_e  state_q, state_d;
    cfgl_status_e status_q, status_d;
    logic         last_q;
    logic         dw_hi;
    logic         crc_hit;
    logic         tmo_run, tmo_clr, tmo_exp;
    logic         hp_run, hp_tick;
    logic         sh_load, sh_shift, sh_bit, sh_last;

    assign crc_hit = !tgt_init_n_i && !tgt_done_i;
    assign tmo_run = (state_q == ST_PROG) || (state_q == ST_RELEASE) ||
                     (state_q == ST_DONE_WAIT);
    assign tmo_clr = (state_d != state_q);
    assign hp_run  = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI) ||
                     (state_q == ST_DONE_WAIT);

    cfgl_timeout #(.LIMIT(TMO_CYC)) i_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .clear   (tmo_clr),
        .expired (tmo_exp)
    );

    cfgl_halfper #(.HALF(HALF_CYC)) i_halfper (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (hp_run),
        .tick  (hp_tick)
    );

    cfgl_shifter #(.W(BYTE_W)) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .shift  (sh_shift),
        .din    (s_data_i),
        .bit_o  (sh_bit),
        .last_o (sh_last)
    );

    // Sequencer: choose the next phase and the completion status.
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_PROG;
            end
            ST_PROG: begin
                if (!tgt_init_n_i) begin
                    state_d = ST_RELEASE;
                end else if (tmo_exp) begin
                    state_d  = ST_FINISH;
                    status_d = CS_INIT_TMO;
                end
            end
            ST_RELEASE: begin
                if (tgt_init_n_i) begin
                    state_d = ST_READY;
                end else if (tmo_exp) begin
                    state_d  = ST_FINISH;
                    status_d = CS_INIT_TMO;
                end
            end
            ST_READY: begin
                if (crc_hit) begin
                    state_d  = ST_FINISH;
                    status_d = CS_CRC;
                end else if (s_valid_i) begin
                    sh_load = 1'b1;
                    state_d = ST_BIT_LO;
                end
            end
            ST_BIT_LO: begin
                if (hp_tick) state_d = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (hp_tick) begin
                    if (sh_last) begin
                        state_d = last_q ? ST_DONE_WAIT : ST_READY;
                    end else begin
                        sh_shift = 1'b1;
                        state_d  = ST_BIT_LO;
                    end
                end
            end
            ST_DONE_WAIT: begin
                if (tgt_done_i) begin
                    state_d  = ST_FINISH;
                    status_d = CS_OK;
                end else if (tmo_exp) begin
                    state_d  = ST_FINISH;
                    status_d = CS_DONE_TMO;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= CS_OK;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // Remember whether the byte being shifted closes the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else if (sh_load) begin
            last_q <= s_last_i;
        end
    end

    // Clock phase during the done-wait, starting low.
    always_ff @(posedge clk) begin
        if (!rst_n || (state_q != ST_DONE_WAIT)) begin
            dw_hi <= 1'b0;
        end else if (hp_tick) begin
            dw_hi <= ~dw_hi;
        end
    end

    // Configuration clock level per phase.
    always_comb begin
        case (state_q)
            ST_BIT_LO:    cfg_clk_o = 1'b0;
            ST_DONE_WAIT: cfg_clk_o = dw_hi;
            default:      cfg_clk_o = 1'b1;
        endcase
    end

    assign cfg_prog_o    = (state_q == ST_PROG);
    assign cfg_data_o    = ((state_q == ST_BIT_LO) || (state_q == ST_BIT_HI)) ? sh_bit : 1'b1;
    assign busy_o        = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign cmpl_o        = (state_q == ST_FINISH);
    assign cmpl_status_o = status_q;
    assign s_ready_o     = (state_q == ST_READY) && !crc_hit;

    assert_prog_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog_o |-> busy_o);

    assert_idle_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cfg_clk_o && !cfg_prog_o));

    assert_cmpl_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_o |=> !cmpl_o);

    assert_accept_starts_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid_i && s_ready_o) |=> !cfg_clk_o);

    assert_data_held_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk_o) |-> $stable(cfg_data_o));

    assert_ok_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_o && (cmpl_status_o == 2'd0)) |-> $past(tgt_done_i));

    assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !cfg_prog_o) |=> !cfg_prog_o);

endmodule

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;

    localparam int HALF = 2;
    localparam int TMO  = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = 8'h00;
    logic       s_last = 1'b0;
    logic       init_n = 1'b1;
    logic       done = 1'b0;
    logic       busy_o, s_ready_o, cmpl_o, cfg_prog_o, cfg_clk_o, cfg_data_o;
    logic [1:0] cmpl_status_o;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    serial_cfg_loader #(.BYTE_W(8), .HALF_CYC(HALF), .TMO_CYC(TMO)) i_serial_cfg_loader (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .busy_o        (busy_o),
        .s_valid_i     (s_valid),
        .s_data_i      (s_data),
        .s_last_i      (s_last),
        .s_ready_o     (s_ready_o),
        .cmpl_o        (cmpl_o),
        .cmpl_status_o (cmpl_status_o),
        .cfg_prog_o    (cfg_prog_o),
        .cfg_clk_o     (cfg_clk_o),
        .cfg_data_o    (cfg_data_o),
        .tgt_init_n_i  (init_n),
        .tgt_done_i    (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: stage 0 idle, 1 program, 2 release, 3 between
    // bytes, 4 shifting, 5 done-wait, 6 completion.
    int m_stage = 0, m_tmr = 0, m_sub = 0, m_phase = 0, m_stat = 0;
    bit m_last = 1'b0;
    bit m_bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_tmr = 0; m_sub = 0; m_phase = 0;
            m_bits.delete();
        end else begin
            case (m_stage)
                0: if (start) begin m_stage = 1; m_tmr = 0; end
                1: begin
                    if (!init_n) begin m_stage = 2; m_tmr = 0; end
                    else if (m_tmr == TMO - 1) begin m_stage = 6; m_stat = 1; end
                    else m_tmr++;
                end
                2: begin
                    if (init_n) m_stage = 3;
                    else if (m_tmr == TMO - 1) begin m_stage = 6; m_stat = 1; end
                    else m_tmr++;
                end
                3: begin
                    if (!init_n && !done) begin m_stage = 6; m_stat = 2; end
                    else if (s_valid) begin
                        for (int b = 7; b >= 0; b--) m_bits.push_back(s_data[b]);
                        m_last = s_last; m_stage = 4; m_sub = 0; m_phase = 0;
                    end
                end
                4: begin
                    m_sub++;
                    if (m_sub == HALF) begin
                        m_sub = 0;
                        if (m_phase == 0) m_phase = 1;
                        else begin
                            m_phase = 0;
                            void'(m_bits.pop_front());
                            if (m_bits.size() == 0) begin
                                m_stage = m_last ? 5 : 3;
                                m_tmr = 0;
                            end
                        end
                    end
                end
                5: begin
                    if (done) begin m_stage = 6; m_stat = 0; end
                    else if (m_tmr == TMO - 1) begin m_stage = 6; m_stat = 3; end
                    else begin
                        m_tmr++; m_sub++;
                        if (m_sub == HALF) begin m_sub = 0; m_phase ^= 1; end
                    end
                end
                default: m_stage = 0;
            endcase
        end
    end

    // Per-cycle comparison and target-side bit capture.
    bit cap[$];
    logic prev_cclk = 1'b1;
    always begin
        @(posedge clk);
        #1;
        check(cfg_prog_o == (m_stage == 1), "R2", "prog", cfg_prog_o, m_stage == 1);
        check(cfg_clk_o == ((m_stage == 4 || m_stage == 5) ? m_phase[0] : 1'b1), "R5", "cclk",
              cfg_clk_o, (m_stage == 4 || m_stage == 5) ? m_phase : 1);
        check(cfg_data_o == ((m_stage == 4) ? m_bits[0] : 1'b1), "R4", "data",
              cfg_data_o, (m_stage == 4) ? int'(m_bits[0]) : 1);
        check(busy_o == (m_stage >= 1 && m_stage <= 5), "R10", "busy",
              busy_o, m_stage >= 1 && m_stage <= 5);
        check(s_ready_o == (m_stage == 3 && !(!init_n && !done)), "R7", "ready",
              s_ready_o, m_stage == 3 && !(!init_n && !done));
        check(cmpl_o == (m_stage == 6), "R10", "cmpl", cmpl_o, m_stage == 6);
        if (m_stage == 6)
            check(cmpl_status_o == m_stat[1:0], "R9", "status", cmpl_status_o, m_stat);
        if (cfg_clk_o && !prev_cclk && busy_o) cap.push_back(cfg_data_o);
        prev_cclk = cfg_clk_o;
    end

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic handshake(input int lo, input int hi);
        repeat (lo) @(negedge clk);
        init_n = 1'b0;
        @(negedge clk);
        check(cfg_prog_o == 1'b0, "R2", "prog after init low", cfg_prog_o, 0);
        repeat (hi) @(negedge clk);
        init_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, input bit lst);
        bit ok;
        int n = 0;
        s_valid = 1'b1; s_data = b; s_last = lst;
        forever begin
            #1;
            ok = s_ready_o;
            @(posedge clk);
            if (ok || n > 5000) break;
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    task automatic wait_cmpl(output int st, output int cyc);
        cyc = 0;
        while (!cmpl_o && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        st = cmpl_status_o;
        check(busy_o == 1'b0, "R10", "busy at completion", busy_o, 0);
        @(negedge clk);
        check(cmpl_o == 1'b0, "R10", "pulse width", cmpl_o, 0);
        check(cfg_clk_o && !cfg_prog_o, "R10", "idle pins", {cfg_clk_o, cfg_prog_o}, 2);
    endtask

    task automatic check_bits(input logic [7:0] bytes[$]);
        int bad = 0;
        if (cap.size() < 8 * bytes.size()) bad = 1;
        else
            foreach (bytes[i])
                for (int b = 0; b < 8; b++)
                    if (cap[i * 8 + b] != bytes[i][7 - b]) bad++;
        check(bad == 0, "R4", "captured bit mismatches", bad, 0);
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int st, cyc;
        logic [7:0] q[$];
        repeat (4) @(negedge clk);
        check({cfg_prog_o, cfg_clk_o, cfg_data_o, busy_o, s_ready_o, cmpl_o} == 6'b011000,
              "R1", "reset outputs", {cfg_prog_o, cfg_clk_o, cfg_data_o, busy_o, s_ready_o, cmpl_o}, 6'b011000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(s_ready_o == 1'b0, "R7", "ready while idle", s_ready_o, 0);

        // Normal load with a gap on the stream and a start while busy.
        cap.delete();
        do_start();
        check(cfg_prog_o && busy_o, "R2", "prog after start", {cfg_prog_o, busy_o}, 3);
        handshake(3, 4);
        send(8'hA5, 1'b0);
        do_start();
        repeat (3) begin
            check(cfg_prog_o == 1'b0, "R11", "start ignored while busy", cfg_prog_o, 0);
            @(negedge clk);
        end
        repeat (40) @(negedge clk);
        send(8'h3C, 1'b0);
        send(8'h81, 1'b1);
        repeat (45) @(negedge clk);
        done = 1'b1;
        wait_cmpl(st, cyc);
        check(st == 0, "R8", "status after done", st, 0);
        done = 1'b0;
        q = {8'hA5, 8'h3C, 8'h81};
        check_bits(q);
        repeat (3) @(negedge clk);

        // Init never falls.
        do_start();
        wait_cmpl(st, cyc);
        check(st == 1, "R3", "init-low timeout status", st, 1);
        check(cyc == TMO, "R3", "init-low timeout cycles", cyc, TMO);
        repeat (3) @(negedge clk);

        // Init falls but never returns high.
        do_start();
        repeat (2) @(negedge clk);
        init_n = 1'b0;
        wait_cmpl(st, cyc);
        check(st == 1, "R3", "init-high timeout status", st, 1);
        init_n = 1'b1;
        repeat (3) @(negedge clk);

        // CRC condition raised during the first byte, second byte offered.
        cap.delete();
        do_start();
        handshake(1, 2);
        send(8'h96, 1'b0);
        init_n = 1'b0;
        s_valid = 1'b1; s_data = 8'h55;
        wait_cmpl(st, cyc);
        check(st == 2, "R6", "crc status", st, 2);
        check(cap.size() == 8, "R6", "bits sent before abort", cap.size(), 8);
        s_valid = 1'b0; init_n = 1'b1;
        q = {8'h96};
        check_bits(q);
        repeat (3) @(negedge clk);

        // Done never rises.
        do_start();
        handshake(1, 1);
        send(8'hC3, 1'b1);
        wait_cmpl(st, cyc);
        check(st == 3, "R9", "done timeout status", st, 3);
        repeat (3) @(negedge clk);

        // Done already high before the final byte ends.
        cap.delete();
        do_start();
        handshake(2, 2);
        send(8'hFF, 1'b0);
        done = 1'b1;
        send(8'h00, 1'b1);
        wait_cmpl(st, cyc);
        check(st == 0, "R8", "status with early done", st, 0);
        done = 1'b0;
        q = {8'hFF, 8'h00};
        check_bits(q);
        repeat (5) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule